// File: doc/BRIEF.md
# Parallel Port Mode Negotiation Controller

This block is the host side of the handshake that moves a parallel port out of compatibility mode into an extended mode, and back again. A request carries an 8-bit mode code. The block puts that code on the data lines and then works through the event sequence of the negotiation. At each step it drives the host control lines and watches the peripheral status lines. At the end it reports whether the peripheral took the mode. A separate request runs the termination sequence. That sequence returns the lines to the compatibility idle pattern.

Every wait is measured in ticks of an external timebase enable, and each wait has its own limit. A status condition seen on any clock ends the wait at once. When a wait runs out, the block reports the result that belongs to that step: a timeout or an I/O error. Each finished operation gives a one-cycle `done` pulse. The result flags are held until the next request that the block takes. All control pins are shown at their line levels, 1 meaning high.

Top module: `pport_mode_ctrl`

## Requirements
- R1: After reset the control lines are strobeN=1, autoFdN=1, initN=1 and selectInN=0. dataOut is 0x00, and done, accepted, rejected, timeout and ioError are all 0.
- R2: Suppose a negotiation request arrives while selectInN is already high. On the next cycle the block pulses done with ioError=1. The control lines and dataOut stay unchanged.
- R3: A taken negotiation request puts modeCode on dataOut on the next cycle, with the control lines unchanged. On the first tick after that, the lines become selectInN=1, autoFdN=0, strobeN=1 and initN=1.
- R4: The block then waits for paperErr, select and faultN all high with ackN low. If this condition is absent, done and timeout rise at the edge of the 6th tick. The control lines stay as they are.
- R5: When that condition is seen, strobeN goes low on the next cycle. strobeN stays low until one tick passes. On that tick edge, strobeN and autoFdN go high together. A condition seen on the same cycle as the tick that would expire the wait takes precedence over the timeout.
- R6: The block then waits for ackN high. If ackN is still low at the edge of the 7th tick, done and ioError rise.
- R7: When ackN goes high in that wait, done rises. Mode code 0x00 gives accepted=1 whatever select is. Any other code gives accepted=1 when select is high, and rejected=1 when select is low. The lines stay all high (0b1111 in the order selectInN, initN, autoFdN, strobeN).
- R8: A terminate request sets selectInN=0, autoFdN=1, strobeN=1 and initN=1 on the next cycle. The block then waits for busy and faultN high with ackN low. If that condition is absent, done and timeout rise at the 7th tick edge, and the lines keep the idle pattern.
- R9: Once the terminate condition is seen, autoFdN goes low. If ackN goes high within 6 ticks, autoFdN returns high with done and no flag set. Otherwise autoFdN returns high at the 6th tick edge, with done and ioError.
- R10: A request that arrives while an operation is running is ignored. If both requests arrive in the same cycle while the block is idle, termination wins.
- R11: done is high for one cycle per finished operation. accepted, rejected, timeout and ioError hold until the next request the block takes. When that request is taken, they are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one cycle per tick |
| negReq | input | 1 | Start negotiation |
| modeCode | input | 8 | Extended mode code to negotiate |
| termReq | input | 1 | Start termination |
| ackN | input | 1 | Peripheral ack line level |
| busy | input | 1 | Peripheral busy line level |
| paperErr | input | 1 | Peripheral paper-error line level |
| select | input | 1 | Peripheral select line level |
| faultN | input | 1 | Peripheral fault line level |
| dataOut | output | 8 | Host data lines |
| strobeN | output | 1 | Strobe line level |
| autoFdN | output | 1 | Auto-feed line level |
| initN | output | 1 | Init line level |
| selectInN | output | 1 | Select-in line level |
| done | output | 1 | One-cycle end-of-operation pulse |
| accepted | output | 1 | Mode taken by peripheral |
| rejected | output | 1 | Mode refused by peripheral |
| timeout | output | 1 | Peripheral response step timed out |
| ioError | output | 1 | Handshake step failed or request refused |

## Verification
A request or a status change applied before a clock edge shows its effect on the pins or flags one cycle later, because every output is a register. A tick that ends a wait shows its effect on the edge that sampled it. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each check falls in the cycle where the result is due. For the timeout checks, the bench gives exactly one tick less than the limit and confirms done is still low. It then gives the final tick and checks the flag on that edge.

// File: rtl/pport_mode_pkg.sv
`timescale 1ns/1ps
package pport_mode_pkg;

  // Edits the control stage asks the datapath to apply to the host lines.
  typedef enum logic [2:0] {
    PIN_HOLD,
    PIN_IDLE,
    PIN_REQ,
    PIN_STB_LO,
    PIN_STB_HI,
    PIN_AFD_LO,
    PIN_AFD_HI
  } pinOp_e;

  // Which wait limit the shared tick counter compares against.
  typedef enum logic [2:0] {
    LIM_SETUP,
    LIM_RESP,
    LIM_HOLD,
    LIM_LATCH,
    LIM_TACK,
    LIM_TFIN
  } limSel_e;

  typedef struct packed {
    logic    loadData;
    logic    clrTimer;
    limSel_e limSel;
    pinOp_e  pinOp;
  } ctlStrobe_t;

  typedef struct packed {
    logic selectInN;
    logic initN;
    logic autoFdN;
    logic strobeN;
  } hostPins_t;

  localparam hostPins_t PINS_IDLE = '{selectInN: 1'b0, initN: 1'b1, autoFdN: 1'b1, strobeN: 1'b1};
  localparam hostPins_t PINS_REQ  = '{selectInN: 1'b1, initN: 1'b1, autoFdN: 1'b0, strobeN: 1'b1};

endpackage

// File: rtl/pport_mode_dp.sv
`timescale 1ns/1ps
module pport_mode_dp
  import pport_mode_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SETUP_TICKS = 1,
  parameter int RESP_TICKS  = 6,
  parameter int HOLD_TICKS  = 1,
  parameter int LATCH_TICKS = 7,
  parameter int TACK_TICKS  = 7,
  parameter int TFIN_TICKS  = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  ctlStrobe_t    ctl,
  input  logic [DW-1:0] modeCode,
  output logic [DW-1:0] dataOut,
  output hostPins_t     pins,
  output logic          expired
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXT = maxOf(maxOf(maxOf(SETUP_TICKS, RESP_TICKS), maxOf(HOLD_TICKS, LATCH_TICKS)),
                              maxOf(TACK_TICKS, TFIN_TICKS));
  localparam int CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limVal;

  always_comb begin
    case (ctl.limSel)
      LIM_SETUP: limVal = CW'(SETUP_TICKS);
      LIM_RESP:  limVal = CW'(RESP_TICKS);
      LIM_HOLD:  limVal = CW'(HOLD_TICKS);
      LIM_LATCH: limVal = CW'(LATCH_TICKS);
      LIM_TACK:  limVal = CW'(TACK_TICKS);
      LIM_TFIN:  limVal = CW'(TFIN_TICKS);
      default:   limVal = CW'(SETUP_TICKS);
    endcase
  end

  // The wait runs out on the tick that brings the count to the limit.
  assign expired = tick && (cnt == limVal - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.clrTimer) begin
      cnt <= '0;
    end else if (tick && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
    end else if (ctl.loadData) begin
      dataOut <= modeCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pins <= PINS_IDLE;
    end else begin
      case (ctl.pinOp)
        PIN_IDLE:   pins <= PINS_IDLE;
        PIN_REQ:    pins <= PINS_REQ;
        PIN_STB_LO: pins.strobeN <= 1'b0;
        PIN_STB_HI: begin
          pins.strobeN <= 1'b1;
          pins.autoFdN <= 1'b1;
        end
        PIN_AFD_LO: pins.autoFdN <= 1'b0;
        PIN_AFD_HI: pins.autoFdN <= 1'b1;
        default:    ;
      endcase
    end
  end

  // R4 R6 R8 R9: an open wait never counts past its own limit
  a_r4_wait_within_limit: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.clrTimer |-> (cnt < limVal));

  // R5: strobe is pulsed only inside the negotiation window
  a_r5_strobe_only_negotiating: assert property (@(posedge clk) disable iff (!rstN)
    !pins.strobeN |-> (pins.selectInN && !pins.autoFdN && pins.initN));

  // R8: init never drops in this block
  a_r8_init_stays_high: assert property (@(posedge clk) disable iff (!rstN)
    pins.initN);

endmodule

// File: rtl/pport_mode_fsm.sv
`timescale 1ns/1ps
module pport_mode_fsm
  import pport_mode_pkg::*;
#(
  parameter int          DW          = 8,
  parameter logic [DW-1:0] NIBBLE_CODE = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          negReq,
  input  logic          termReq,
  input  logic [DW-1:0] codeHeld,
  input  logic          selectInN,
  input  logic          expired,
  input  logic          ackN,
  input  logic          busy,
  input  logic          paperErr,
  input  logic          select,
  input  logic          faultN,
  output ctlStrobe_t    ctl,
  output logic          done,
  output logic          accepted,
  output logic          rejected,
  output logic          timeout,
  output logic          ioError
);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_RESP, S_HOLD, S_LATCH, S_TACK, S_TFIN
  } state_e;

  state_e stateQ, stateNxt;

  logic start, fin, finAcc, finRej, finTo, finIo;
  logic respOk, tackOk, modeOk;

  assign respOk = paperErr && select && faultN && !ackN;
  assign tackOk = busy && faultN && !ackN;
  assign modeOk = (codeHeld == NIBBLE_CODE) || select;

  always_comb begin
    stateNxt   = stateQ;
    ctl        = '{loadData: 1'b0, clrTimer: 1'b0, limSel: LIM_SETUP, pinOp: PIN_HOLD};
    start      = 1'b0;
    fin        = 1'b0;
    finAcc     = 1'b0;
    finRej     = 1'b0;
    finTo      = 1'b0;
    finIo      = 1'b0;
    case (stateQ)
      S_IDLE: begin
        ctl.clrTimer = 1'b1;
        if (termReq) begin
          start     = 1'b1;
          ctl.pinOp = PIN_IDLE;
          stateNxt  = S_TACK;
        end else if (negReq) begin
          if (selectInN) begin
            fin   = 1'b1;
            finIo = 1'b1;
          end else begin
            start        = 1'b1;
            ctl.loadData = 1'b1;
            stateNxt     = S_SETUP;
          end
        end
      end
      S_SETUP: begin
        ctl.limSel = LIM_SETUP;
        if (expired) begin
          ctl.pinOp    = PIN_REQ;
          ctl.clrTimer = 1'b1;
          stateNxt     = S_RESP;
        end
      end
      S_RESP: begin
        ctl.limSel = LIM_RESP;
        if (respOk) begin
          ctl.pinOp    = PIN_STB_LO;
          ctl.clrTimer = 1'b1;
          stateNxt     = S_HOLD;
        end else if (expired) begin
          fin      = 1'b1;
          finTo    = 1'b1;
          stateNxt = S_IDLE;
        end
      end
      S_HOLD: begin
        ctl.limSel = LIM_HOLD;
        if (expired) begin
          ctl.pinOp    = PIN_STB_HI;
          ctl.clrTimer = 1'b1;
          stateNxt     = S_LATCH;
        end
      end
      S_LATCH: begin
        ctl.limSel = LIM_LATCH;
        if (ackN) begin
          fin      = 1'b1;
          finAcc   = modeOk;
          finRej   = !modeOk;
          stateNxt = S_IDLE;
        end else if (expired) begin
          fin      = 1'b1;
          finIo    = 1'b1;
          stateNxt = S_IDLE;
        end
      end
      S_TACK: begin
        ctl.limSel = LIM_TACK;
        if (tackOk) begin
          ctl.pinOp    = PIN_AFD_LO;
          ctl.clrTimer = 1'b1;
          stateNxt     = S_TFIN;
        end else if (expired) begin
          fin      = 1'b1;
          finTo    = 1'b1;
          stateNxt = S_IDLE;
        end
      end
      S_TFIN: begin
        ctl.limSel = LIM_TFIN;
        if (ackN || expired) begin
          ctl.pinOp = PIN_AFD_HI;
          fin       = 1'b1;
          finIo     = !ackN;
          stateNxt  = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      done     <= 1'b0;
      accepted <= 1'b0;
      rejected <= 1'b0;
      timeout  <= 1'b0;
      ioError  <= 1'b0;
    end else begin
      stateQ <= stateNxt;
      done   <= fin;
      if (fin) begin
        accepted <= finAcc;
        rejected <= finRej;
        timeout  <= finTo;
        ioError  <= finIo;
      end else if (start) begin
        accepted <= 1'b0;
        rejected <= 1'b0;
        timeout  <= 1'b0;
        ioError  <= 1'b0;
      end
    end
  end

  // R2: a request against a port already out of compatibility is refused
  a_r2_refuse_when_selected: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_IDLE && negReq && !termReq && selectInN) |=> (done && ioError && !accepted));

  // R4: a missing peripheral response ends in a timeout
  a_r4_resp_timeout: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_RESP && !respOk && expired) |=> (done && timeout));

  // R7: an accepted mode leaves select-in high
  a_r7_accept_keeps_select: assert property (@(posedge clk) disable iff (!rstN)
    (done && accepted) |-> selectInN);

  // R9: ack high in the final termination step is a clean finish
  a_r9_clean_finish: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_TFIN && ackN) |=> (done && !ioError && !timeout));

  // R10: the data lines only change from idle
  a_r10_data_frozen_busy: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != S_IDLE) |=> $stable(codeHeld));

  // R11: at most one result flag accompanies done
  a_r11_single_result: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($countones({accepted, rejected, timeout, ioError}) <= 1));

endmodule

// File: rtl/pport_mode_ctrl.sv
`timescale 1ns/1ps
module pport_mode_ctrl
  import pport_mode_pkg::*;
#(
  parameter int            DW          = 8,
  parameter logic [DW-1:0] NIBBLE_CODE = '0,
  parameter int            SETUP_TICKS = 1,
  parameter int            RESP_TICKS  = 6,
  parameter int            HOLD_TICKS  = 1,
  parameter int            LATCH_TICKS = 7,
  parameter int            TACK_TICKS  = 7,
  parameter int            TFIN_TICKS  = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          negReq,
  input  logic [DW-1:0] modeCode,
  input  logic          termReq,
  input  logic          ackN,
  input  logic          busy,
  input  logic          paperErr,
  input  logic          select,
  input  logic          faultN,
  output logic [DW-1:0] dataOut,
  output logic          strobeN,
  output logic          autoFdN,
  output logic          initN,
  output logic          selectInN,
  output logic          done,
  output logic          accepted,
  output logic          rejected,
  output logic          timeout,
  output logic          ioError
);

  ctlStrobe_t ctl;
  hostPins_t  pinsQ;
  logic       expired;

  pport_mode_fsm #(
    .DW(DW), .NIBBLE_CODE(NIBBLE_CODE)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .negReq(negReq), .termReq(termReq),
    .codeHeld(dataOut), .selectInN(pinsQ.selectInN), .expired(expired),
    .ackN(ackN), .busy(busy), .paperErr(paperErr), .select(select), .faultN(faultN),
    .ctl(ctl), .done(done), .accepted(accepted), .rejected(rejected),
    .timeout(timeout), .ioError(ioError)
  );

  pport_mode_dp #(
    .DW(DW), .SETUP_TICKS(SETUP_TICKS), .RESP_TICKS(RESP_TICKS), .HOLD_TICKS(HOLD_TICKS),
    .LATCH_TICKS(LATCH_TICKS), .TACK_TICKS(TACK_TICKS), .TFIN_TICKS(TFIN_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .ctl(ctl), .modeCode(modeCode),
    .dataOut(dataOut), .pins(pinsQ), .expired(expired)
  );

  assign strobeN   = pinsQ.strobeN;
  assign autoFdN   = pinsQ.autoFdN;
  assign initN     = pinsQ.initN;
  assign selectInN = pinsQ.selectInN;

endmodule

// File: tb/pport_mode_ctrl_test.sv
`timescale 1ns/1ps
module pport_mode_ctrl_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, tick, negReq, termReq;
  logic [7:0] modeCode;
  logic       ackN, busy, paperErr, select, faultN;
  logic [7:0] dataOut;
  logic       strobeN, autoFdN, initN, selectInN;
  logic       done, accepted, rejected, timeout, ioError;

  int nRun  = 0;
  int nFail = 0;

  pport_mode_ctrl uut (
    .clk(clk), .rstN(rstN), .tick(tick), .negReq(negReq), .modeCode(modeCode),
    .termReq(termReq), .ackN(ackN), .busy(busy), .paperErr(paperErr),
    .select(select), .faultN(faultN), .dataOut(dataOut), .strobeN(strobeN),
    .autoFdN(autoFdN), .initN(initN), .selectInN(selectInN), .done(done),
    .accepted(accepted), .rejected(rejected), .timeout(timeout), .ioError(ioError)
  );

  // line patterns, order selectInN initN autoFdN strobeN
  localparam int P_IDLE = 4'b0111;
  localparam int P_REQ  = 4'b1101;
  localparam int P_STB  = 4'b1100;
  localparam int P_EXT  = 4'b1111;
  localparam int P_AFD  = 4'b0101;

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pinsNow();
    return int'({selectInN, initN, autoFdN, strobeN});
  endfunction

  function automatic int flagsNow();
    return int'({done, accepted, rejected, timeout, ioError});
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tickOnce();
    tick = 1'b1;
    cyc();
    tick = 1'b0;
  endtask

  task automatic negPulse(input logic [7:0] code);
    modeCode = code;
    negReq   = 1'b1;
    cyc();
    negReq   = 1'b0;
  endtask

  task automatic termPulse();
    termReq = 1'b1;
    cyc();
    termReq = 1'b0;
  endtask

  task automatic periphIdle();
    ackN = 1'b1; busy = 1'b0; paperErr = 1'b0; select = 1'b0; faultN = 1'b1;
  endtask

  task automatic respond();
    paperErr = 1'b1; select = 1'b1; faultN = 1'b1; ackN = 1'b0;
  endtask

  task automatic negotiateFull(input logic [7:0] code, input logic sel);
    logic acc;
    acc = (code == 8'h00) || sel;
    periphIdle();
    negPulse(code);
    chk("R3 data lines carry code", int'(dataOut), int'(code));
    chk("R3 lines unchanged before tick", pinsNow(), P_IDLE);
    chk("R11 flags cleared on new request", flagsNow(), 0);
    tickOnce();
    chk("R3 request pattern after setup tick", pinsNow(), P_REQ);
    respond();
    cyc();
    chk("R5 strobe low after response", pinsNow(), P_STB);
    tickOnce();
    chk("R5 strobe and autofeed rise together", pinsNow(), P_EXT);
    select = sel;
    ackN   = 1'b1;
    cyc();
    chk("R7 mode decision", flagsNow(), int'({1'b1, acc, ~acc, 2'b00}));
    chk("R7 lines after decision", pinsNow(), P_EXT);
    cyc();
    chk("R11 done is one cycle, result held", flagsNow(), int'({1'b0, acc, ~acc, 2'b00}));
  endtask

  task automatic termFull();
    termPulse();
    chk("R8 idle pattern on terminate", pinsNow(), P_IDLE);
    busy = 1'b1; faultN = 1'b1; ackN = 1'b0;
    cyc();
    chk("R9 autofeed low after termination ack", pinsNow(), P_AFD);
    ackN = 1'b1;
    cyc();
    chk("R9 clean termination", flagsNow(), 5'b10000);
    chk("R9 idle pattern restored", pinsNow(), P_IDLE);
    periphIdle();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] codes [4];
    codes = '{8'h00, 8'h30, 8'h10, 8'hFF};
    rstN = 1'b0; tick = 1'b0; negReq = 1'b0; termReq = 1'b0; modeCode = 8'h00;
    periphIdle();
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    chk("R1 reset lines", pinsNow(), P_IDLE);
    chk("R1 reset data", int'(dataOut), 0);
    chk("R1 reset flags", flagsNow(), 0);

    // sweep mode codes against both select answers
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 2; s++) begin
        negotiateFull(codes[c], s[0]);
        if (s == 1) begin
          negPulse(8'hA5);
          chk("R2 refusal flags", flagsNow(), 5'b10001);
          chk("R2 refusal keeps lines", pinsNow(), P_EXT);
          chk("R2 refusal keeps data", int'(dataOut), int'(codes[c]));
        end
        termFull();
      end
    end

    // R4 response timeout at the 6th tick
    negPulse(8'h30);
    tickOnce();
    for (int i = 1; i < 6; i++) begin
      tickOnce();
      chk("R4 no timeout before limit", int'(done), 0);
    end
    tickOnce();
    chk("R4 response timeout", flagsNow(), 5'b10010);
    chk("R4 lines held", pinsNow(), P_REQ);

    // R8 termination ack timeout at the 7th tick
    termPulse();
    chk("R8 idle pattern on terminate", pinsNow(), P_IDLE);
    for (int i = 1; i < 7; i++) begin
      tickOnce();
      chk("R8 no timeout before limit", int'(done), 0);
    end
    tickOnce();
    chk("R8 termination timeout", flagsNow(), 5'b10010);
    chk("R8 lines idle after timeout", pinsNow(), P_IDLE);

    // R6 latch wait timeout at the 7th tick
    negPulse(8'h00);
    tickOnce();
    respond();
    cyc();
    tickOnce();
    chk("R6 lines before latch wait", pinsNow(), P_EXT);
    for (int i = 1; i < 7; i++) begin
      tickOnce();
      chk("R6 no error before limit", int'(done), 0);
    end
    tickOnce();
    chk("R6 latch wait error", flagsNow(), 5'b10001);

    // R9 final termination step timeout at the 6th tick
    termPulse();
    busy = 1'b1; faultN = 1'b1; ackN = 1'b0;
    cyc();
    chk("R9 autofeed low", pinsNow(), P_AFD);
    for (int i = 1; i < 6; i++) begin
      tickOnce();
      chk("R9 no error before limit", int'(done), 0);
    end
    tickOnce();
    chk("R9 final step error", flagsNow(), 5'b10001);
    chk("R9 autofeed raised on error", pinsNow(), P_IDLE);
    periphIdle();

    // R10 requests ignored while busy
    negPulse(8'h30);
    negReq = 1'b1; termReq = 1'b1; modeCode = 8'h77;
    cyc();
    negReq = 1'b0; termReq = 1'b0;
    chk("R10 busy request leaves data", int'(dataOut), 8'h30);
    chk("R10 busy request leaves lines", pinsNow(), P_IDLE);
    tickOnce();
    chk("R10 negotiation continues", pinsNow(), P_REQ);
    respond();
    cyc();
    tickOnce();
    ackN = 1'b1;
    cyc();
    chk("R10 negotiation completes", flagsNow(), 5'b11000);
    termFull();

    // R5 response on the expiring tick wins over the timeout
    negPulse(8'h30);
    tickOnce();
    for (int i = 1; i < 6; i++) tickOnce();
    respond();
    tickOnce();
    chk("R5 response beats expiry", pinsNow(), P_STB);
    chk("R5 no timeout flagged", flagsNow(), 0);
    tickOnce();
    ackN = 1'b1;
    cyc();
    chk("R7 accepted after late response", flagsNow(), 5'b11000);
    termFull();

    // R10 simultaneous requests from idle: terminate wins
    modeCode = 8'h10;
    negReq = 1'b1; termReq = 1'b1;
    cyc();
    negReq = 1'b0; termReq = 1'b0;
    chk("R10 data not loaded", int'(dataOut), 8'h30);
    tickOnce();
    chk("R10 lines stay idle under terminate", pinsNow(), P_IDLE);
    for (int i = 2; i < 7; i++) begin
      tickOnce();
      chk("R10 terminate still waiting", int'(done), 0);
    end
    tickOnce();
    chk("R10 terminate path timed out", flagsNow(), 5'b10010);

    summary();
    $finish;
  end

endmodule